// File: doc/BRIEF.md
# BCD Calendar Clock with Frozen Host View

This block keeps calendar time as packed BCD counters: hundredths of a second, seconds, minutes, hours (24-hour), day of week, day of month, month and two-digit year. A century flag sits beside the year, with an enable that lets the flag toggle when the year wraps. A one-cycle `tick_i` pulse at 100 Hz advances the count. Month lengths are taken into account, and 29 February is kept in years divisible by four.

A host reaches the eight time bytes through a byte-wide register port. `start_i` loads an address pointer from `addr_i`. Each `rd_i` or `wr_i` strobe then uses the byte at the pointer and moves the pointer on by one. A burst that starts inside addresses 0 to 7 reads a snapshot taken at the start strobe, so every byte comes from one instant even when a carry ripples through the counters during the burst. The live counters never pause. The snapshot is dropped when the pointer steps from 7 to 8, or when `end_i` is pulsed.

Host writes go straight into the live counters.

Top module: `bcd_rtc_core`

## Requirements
- R1: Address 0 reads hundredths, address 1 reads {stop, seconds[6:0]}, address 2 reads minutes in bits 6:0, address 3 reads {century-toggle enable in bit 7, century flag in bit 6, hours in bits 5:0}, address 4 reads day of week in bits 2:0, address 5 reads day of month in bits 5:0, address 6 reads month in bits 4:0, and address 7 reads year. Unused bits read 0. Addresses 8 to 15 read 0x00. After reset the time reads 00:00:00.00, weekday 1, day 01, month 01, year 00, with both century bits clear.
- R2: Each tick advances the count in BCD. Hundredths run 00 to 99, seconds and minutes run 00 to 59, and hours run 00 to 23. Each wrap carries into the next field. Every digit stays within 0 to 9, provided the host writes valid BCD.
- R3: Day of week counts 1 to 7, advances at midnight, and wraps from 7 to 1.
- R4: While bit 7 of the seconds byte is 1, ticks change nothing. Writing that bit back to 0 resumes counting.
- R5: At midnight, day of month wraps to 01 after the last day of the month. The last day is 30 for April, June, September and November, and 31 for the other months except February. February ends on 29 when the BCD year is divisible by 4 and on 28 otherwise.
- R6: Month wraps from 12 to 01 and carries into the year. Year wraps from 99 to 00. On that year wrap the century flag inverts if the enable bit (hours byte bit 7) is 1, and is left unchanged if the enable bit is 0.
- R7: A write strobe loads the live byte at the pointer; bits that are unused for that byte are dropped. Writing address 1 also clears the hundredths to 00.
- R8: A start strobe with an address below 8 captures all eight bytes. Reads then return the captured bytes, while ticks keep advancing the live counters underneath.
- R9: The captured view is released when a read or write strobe at address 7 moves the pointer to 8, or when `end_i` is pulsed. From the next cycle on, reads follow the live counters.
- R10: Each read or write strobe increments the pointer, wrapping from 15 to 0. When a start strobe arrives in the same cycle as a read or write strobe, the start strobe wins and the other strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 100 Hz advance pulse, one cycle wide |
| start_i | input | 1 | Begin access: load the pointer from addr_i |
| addr_i | input | ADDR_W | Start address |
| rd_i | input | 1 | Read strobe: consume the byte at the pointer and increment |
| wr_i | input | 1 | Write strobe: load wdata_i at the pointer and increment |
| wdata_i | input | 8 | Write data |
| end_i | input | 1 | End access: release the captured view |
| rdata_o | output | 8 | Byte at the pointer (combinational) |

## Verification
The bound checker watches the following on every cycle:
- the stability of the read data while the view is held;
- the live counter moving under a hold;
- the release at the step from address 7 to 8;
- the halt while the stop bit is set;
- the clearing of hundredths on a seconds write;
- pointer increments and BCD digit ranges.

Month-length rollover, leap Februaries, weekday wrap, century toggling with and without the enable bit, and a burst read that straddles a seconds carry can only be shown by the bench's scenarios. Those scenarios preset a time, apply a counted number of ticks and read the result back.

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic              end_i,
  output logic [7:0]        rdata_o
);
  localparam logic [ADDR_W-1:0] TIME_REGS = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] LAST_TIME = ADDR_W'(7);
  localparam logic [7:0][7:0] WMASK = {8'hFF, 8'h1F, 8'h3F, 8'h07, 8'hFF, 8'h7F, 8'hFF, 8'hFF};
  localparam logic [7:0][7:0] RESET_VAL = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};

  logic [7:0][7:0]   live, nxt, shadow;
  logic [ADDR_W-1:0] ptr;
  logic              frozen_q;

  wire in_time = ptr < TIME_REGS;
  wire access  = (rd_i || wr_i) && !start_i;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic [8:0] roll(input logic [7:0] v, input logic [7:0] last,
                                      input logic [7:0] first);
    return (v == last) ? {1'b1, first} : {1'b0, bcd_inc(v)};
  endfunction

  function automatic logic [7:0] last_day(input logic [4:0] mon, input logic [7:0] yr);
    logic [7:0] yb;
    yb = {4'd0, yr[7:4]} * 8'd10 + {4'd0, yr[3:0]};
    case (mon)
      5'h02:                      return (yb[1:0] == 2'd0) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  always_comb begin
    logic       c;
    logic [8:0] r;
    nxt = live;
    c   = 1'b0;
    r   = '0;
    if (tick_i && !live[1][7]) begin
      r = roll(live[0], 8'h99, 8'h00);
      nxt[0] = r[7:0];
      c = r[8];
      if (c) begin
        r = roll({1'b0, live[1][6:0]}, 8'h59, 8'h00);
        nxt[1][6:0] = r[6:0];
        c = r[8];
      end
      if (c) begin
        r = roll({1'b0, live[2][6:0]}, 8'h59, 8'h00);
        nxt[2][6:0] = r[6:0];
        c = r[8];
      end
      if (c) begin
        r = roll({2'b0, live[3][5:0]}, 8'h23, 8'h00);
        nxt[3][5:0] = r[5:0];
        c = r[8];
      end
      if (c) begin
        nxt[4] = (live[4][2:0] == 3'd7) ? 8'd1 : {5'd0, live[4][2:0] + 3'd1};
        r = roll({2'b0, live[5][5:0]}, last_day(live[6][4:0], live[7]), 8'h01);
        nxt[5] = r[7:0];
        c = r[8];
      end
      if (c) begin
        r = roll({3'b0, live[6][4:0]}, 8'h12, 8'h01);
        nxt[6] = r[7:0];
        c = r[8];
      end
      if (c) begin
        r = roll(live[7], 8'h99, 8'h00);
        nxt[7] = r[7:0];
        if (r[8] && live[3][7]) nxt[3][6] = ~live[3][6];
      end
    end
    if (wr_i && !start_i && in_time) begin
      nxt[ptr[2:0]] = wdata_i & WMASK[ptr[2:0]];
      if (ptr[2:0] == 3'd1) nxt[0] = 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live     <= RESET_VAL;
      shadow   <= RESET_VAL;
      ptr      <= '0;
      frozen_q <= 1'b0;
    end else begin
      live <= nxt;
      if (start_i || !frozen_q) shadow <= live;
      if (start_i) begin
        ptr      <= addr_i;
        frozen_q <= addr_i < TIME_REGS;
      end else begin
        if (access) ptr <= ptr + ADDR_W'(1);
        if ((access && ptr == LAST_TIME) || end_i) frozen_q <= 1'b0;
      end
    end
  end

  assign rdata_o = in_time ? shadow[ptr[2:0]] : 8'h00;
endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              start_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              end_i,
  input logic [ADDR_W-1:0] ptr,
  input logic              frozen_q,
  input logic [63:0]       live,
  input logic [7:0]        rdata_o
);
  p_frozen_view_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && !start_i && !rd_i && !wr_i && !end_i) |=> $stable(rdata_o));

  p_runs_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && tick_i && !live[15] && !wr_i) |=> (live[7:0] != $past(live[7:0])));

  p_release_at8_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_i || wr_i) && !start_i && ptr == ADDR_W'(7)) |=> !frozen_q);

  p_stop_halts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live[15] && !wr_i) |=> $stable(live));

  p_sec_clears_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !start_i && ptr == ADDR_W'(1)) |=> (live[7:0] == 8'h00));

  p_auto_inc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_i || wr_i) && !start_i) |=> (ptr == ADDR_W'($past(ptr) + ADDR_W'(1))));

  p_bcd_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live[3:0] <= 4'd9 && live[7:4] <= 4'd9 && live[11:8] <= 4'd9 &&
     live[19:16] <= 4'd9 && live[59:56] <= 4'd9 && live[63:60] <= 4'd9));
endmodule

bind bcd_rtc_core bcd_rtc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .start_i(start_i), .rd_i(rd_i),
  .wr_i(wr_i), .end_i(end_i), .ptr(ptr), .frozen_q(frozen_q), .live(live),
  .rdata_o(rdata_o)
);

// File: tb/bcd_rtc_core_tb.sv
module bcd_rtc_core_tb;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0;
  logic       rd = 1'b0, wr = 1'b0, endp = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  bcd_rtc_core #(.ADDR_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start), .addr_i(addr),
    .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .end_i(endp), .rdata_o(rdata)
  );

  // {preset year..hs, ticks, expected year..hs}
  localparam logic [143:0] VEC [15] = '{
    {64'h20_01_15_03_10_30_00_98, 16'd3,   64'h20_01_15_03_10_30_01_01},  // R2 hs carry
    {64'h21_06_15_03_23_59_59_99, 16'd1,   64'h21_06_16_04_00_00_00_00},  // R2 R3 midnight
    {64'h21_06_10_07_23_59_59_99, 16'd1,   64'h21_06_11_01_00_00_00_00},  // R3 weekday 7->1
    {64'h21_04_30_02_23_59_59_99, 16'd1,   64'h21_05_01_03_00_00_00_00},  // R5 30-day month
    {64'h23_02_28_02_23_59_59_99, 16'd1,   64'h23_03_01_03_00_00_00_00},  // R5 plain February
    {64'h24_02_28_03_23_59_59_99, 16'd1,   64'h24_02_29_04_00_00_00_00},  // R5 leap February
    {64'h24_02_29_04_23_59_59_99, 16'd1,   64'h24_03_01_05_00_00_00_00},  // R5 leap day end
    {64'h22_09_30_05_23_59_59_99, 16'd1,   64'h22_10_01_06_00_00_00_00},  // R5 September
    {64'h22_01_31_01_23_59_59_99, 16'd1,   64'h22_02_01_02_00_00_00_00},  // R5 31-day month
    {64'h99_12_31_05_A3_59_59_99, 16'd1,   64'h00_01_01_06_C0_00_00_00},  // R6 toggle 0->1
    {64'h99_12_31_05_63_59_59_99, 16'd1,   64'h00_01_01_06_40_00_00_00},  // R6 no toggle
    {64'h99_12_31_02_E3_59_59_99, 16'd1,   64'h00_01_01_03_80_00_00_00},  // R6 toggle 1->0
    {64'h21_03_03_03_12_34_92_50, 16'd50,  64'h21_03_03_03_12_34_92_50},  // R4 stopped
    {64'h21_03_03_03_09_59_59_99, 16'd1,   64'h21_03_03_03_10_00_00_00},  // R2 hour carry
    {64'h21_03_03_03_00_00_00_00, 16'd150, 64'h21_03_03_03_00_00_01_50}   // R2 many ticks
  };

  task automatic step(input logic s, input logic [3:0] a, input logic r, input logic w,
                      input logic [7:0] d, input logic e, input logic t);
    start = s; addr = a; rd = r; wr = w; wdata = d; endp = e; tick = t;
    @(posedge clk); #1;
    start = 1'b0; rd = 1'b0; wr = 1'b0; endp = 1'b0; tick = 1'b0;
  endtask

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic set_time(input logic [63:0] t);
    step(1, 4'd1, 0, 0, 8'h00, 0, 0);
    for (int i = 1; i < 8; i++) step(0, 4'd0, 0, 1, t[i*8 +: 8], 0, 0);
    step(1, 4'd0, 0, 0, 8'h00, 0, 0);
    step(0, 4'd0, 0, 1, t[7:0], 0, 0);
    step(0, 4'd0, 0, 0, 8'h00, 1, 0);
  endtask

  task automatic read_time(input logic [63:0] e, input string tag);
    step(1, 4'd0, 0, 0, 8'h00, 0, 0);
    for (int i = 0; i < 8; i++) begin
      chk(rdata, e[i*8 +: 8], $sformatf("%s byte %0d", tag, i));
      step(0, 4'd0, 1, 0, 8'h00, 0, 0);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 4'd0, 0, 0, 8'h00, 0, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state and unmapped address
    read_time(64'h00_01_01_01_00_00_00_00, "R1 reset");
    chk(rdata, 8'h00, "R1 addr 8 reads zero");

    for (int v = 0; v < 15; v++) begin
      set_time(VEC[v][143:80]);
      ticks(int'(VEC[v][79:64]));
      read_time(VEC[v][63:0], $sformatf("table %0d", v));
    end

    // R7 seconds write clears hundredths
    set_time(64'h21_03_03_03_10_20_30_42);
    step(1, 4'd1, 0, 0, 8'h00, 0, 0);
    step(0, 4'd0, 0, 1, 8'h45, 0, 0);
    step(0, 4'd0, 0, 0, 8'h00, 1, 0);
    read_time(64'h21_03_03_03_10_20_45_00, "R7 sec write");

    // R8 burst straddling a seconds carry stays consistent
    set_time(64'h21_03_03_03_10_20_05_99);
    step(1, 4'd0, 0, 0, 8'h00, 0, 0);
    chk(rdata, 8'h99, "R8 frozen hs");
    step(0, 4'd0, 1, 0, 8'h00, 0, 0);
    step(0, 4'd0, 0, 0, 8'h00, 0, 1);
    begin
      logic [63:0] e;
      e = 64'h21_03_03_03_10_20_05_99;
      for (int i = 1; i < 8; i++) begin
        chk(rdata, e[i*8 +: 8], $sformatf("R8 frozen byte %0d", i));
        step(0, 4'd0, 1, 0, 8'h00, 0, 0);
      end
    end
    // R9 released at address 8; wrap pointer back to 0 (R10)
    chk(rdata, 8'h00, "R1 addr 8 after burst");
    for (int i = 0; i < 8; i++) step(0, 4'd0, 1, 0, 8'h00, 0, 0);
    chk(rdata, 8'h00, "R9 live hs after carry");
    ticks(3);
    step(0, 4'd0, 0, 0, 8'h00, 0, 0);
    chk(rdata, 8'h03, "R9 view follows live");
    step(1, 4'd1, 0, 0, 8'h00, 0, 0);
    chk(rdata, 8'h06, "R8 live seconds advanced");
    step(0, 4'd0, 0, 0, 8'h00, 1, 0);

    // R9 release by end strobe
    set_time(64'h21_03_03_03_10_20_05_10);
    step(1, 4'd0, 0, 0, 8'h00, 0, 0);
    chk(rdata, 8'h10, "R8 captured hs");
    ticks(3);
    chk(rdata, 8'h10, "R8 held during ticks");
    step(0, 4'd0, 0, 0, 8'h00, 1, 0);
    step(0, 4'd0, 0, 0, 8'h00, 0, 0);
    chk(rdata, 8'h13, "R9 end strobe releases");

    // R10 start wins over a simultaneous read
    step(1, 4'd3, 1, 0, 8'h00, 0, 0);
    chk(rdata, 8'h10, "R10 start beats read");
    step(0, 4'd0, 1, 0, 8'h00, 0, 0);
    chk(rdata, 8'h03, "R10 increment");
    step(0, 4'd0, 0, 0, 8'h00, 1, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule